// File: doc/BRIEF.md
# Serial 8N1 Frame Transmitter

The block turns one byte into a framed asynchronous serial character on a single line. Each character has one low start bit, eight data bits sent most significant bit first, and a high level that acts as both the stop bit and the idle state. All timing comes from an external bit-period tick. The block holds its state between ticks, so a baud generator anywhere else in the chip sets the line rate.

A frame-position counter has ten values. Value 9 means idle/stop, value 0 is the start bit, and values 1 to 8 carry data bits 7 down to 0. When the counter is idle, a one-cycle send strobe copies the byte into a holding register and arms a start. The next tick drives the line low. From then on, each tick moves the frame forward by one bit. The ready output goes low only while the final data bit is on the line.

Top module: `serial_frame_tx`

## Requirements
- R1: After synchronous reset, and whenever reset is applied in the middle of a frame, the line is high (1), ready is high, and no frame is in progress.
- R2: A send strobe accepted while idle makes the line go low (start bit) at the first tick after the strobe cycle. The line stays low until the next tick.
- R3: After the start bit, the next eight bit periods carry the captured byte in the order bit 7, bit 6, …, bit 0 (most significant bit first).
- R4: The tick that ends the bit 0 period returns the line high. A new start bit cannot appear before one more full bit period (tick to tick) has passed.
- R5: Ready is low (0) only during the bit 0 period, which is frame position 8. It is high in every other position.
- R6: In cycles without a tick, the frame position and the line level do not change.
- R7: A send strobe while a frame is in progress is ignored. The byte being sent is not changed and no further frame follows.
- R8: A send strobe in the same cycle as a tick, while idle, captures the byte but does not start on that tick. The start bit comes at the following tick.
- R9: While idle with no accepted strobe, ticks leave the line high.
- R10: A second strobe while a start is already armed (idle, waiting for a tick) is ignored. The first byte is the one sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bitTick | input | 1 | One-cycle pulse per bit period |
| txByte | input | 8 | Byte to send, sampled when a strobe is accepted |
| sendReq | input | 1 | Send strobe, one cycle |
| ready | output | 1 | Low only while the last data bit is on the line |
| txLine | output | 1 | Serial output line, high when idle |

## Verification
The send strobe and the bit-period tick can arrive in the same cycle. The bench provokes this by raising both inputs in one idle cycle. It then judges the result at the line: the line must still be high one cycle later, the start bit must appear only at the next tick, and the full byte must follow intact. The bench also covers a strobe during a frame and a second strobe while a start is armed. These are judged by the bits that actually leave on the line and by the line staying high after the frame ends.

// File: rtl/sftx_pkg.sv
package sftx_pkg;
  // strobes from frame control to the bit datapath
  typedef struct packed {
    logic loadByte;   // copy input byte into holding register
    logic startBit;   // drive the start level
    logic driveData;  // drive the selected data bit
  } sftx_strobe_t;
endpackage

// File: rtl/sftx_ctrl.sv
module sftx_ctrl
  import sftx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  localparam int IDLE_POS = DATA_BITS + 1,
  localparam int LAST_POS = DATA_BITS,
  localparam int POS_W = $clog2(IDLE_POS + 1),
  localparam int SEL_W = $clog2(DATA_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bitTick,
  input  logic             sendReq,
  output sftx_strobe_t     strobes,
  output logic [SEL_W-1:0] bitSel,
  output logic             lineIdle,
  output logic             ready
);
  logic [POS_W-1:0] posQ;
  logic             pendingQ;

  always_comb begin
    lineIdle          = (posQ == POS_W'(IDLE_POS));
    strobes.loadByte  = sendReq & lineIdle & ~pendingQ;
    strobes.startBit  = bitTick & lineIdle & pendingQ;
    strobes.driveData = bitTick & (posQ < POS_W'(DATA_BITS));
    bitSel            = SEL_W'(DATA_BITS - 1) - posQ[SEL_W-1:0];
    ready             = (posQ != POS_W'(LAST_POS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      posQ     <= POS_W'(IDLE_POS);
      pendingQ <= 1'b0;
    end else begin
      if (strobes.loadByte) pendingQ <= 1'b1;
      if (bitTick) begin
        if (lineIdle) begin
          if (pendingQ) begin
            posQ     <= '0;
            pendingQ <= 1'b0;
          end
        end else begin
          posQ <= posQ + POS_W'(1);
        end
      end
    end
  end

  // R6
  tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bitTick |=> $stable(posQ));
  // R2
  start_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (lineIdle && bitTick && pendingQ) |=> (posQ == '0));
  // R9
  idle_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (lineIdle && !pendingQ) |=> (lineIdle || posQ == '0) && posQ != POS_W'(1));
endmodule

// File: rtl/sftx_datapath.sv
module sftx_datapath
  import sftx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  localparam int SEL_W = $clog2(DATA_BITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  sftx_strobe_t         strobes,
  input  logic [SEL_W-1:0]     bitSel,
  input  logic                 lineIdle,
  input  logic [DATA_BITS-1:0] byteIn,
  output logic                 lineOut
);
  logic [DATA_BITS-1:0] holdQ;
  logic                 outBitQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      holdQ   <= '0;
      outBitQ <= 1'b1;
    end else begin
      if (strobes.loadByte)  holdQ <= byteIn;
      if (strobes.startBit)  outBitQ <= 1'b0;
      else if (strobes.driveData) outBitQ <= holdQ[bitSel];
    end
  end

  assign lineOut = lineIdle | outBitQ;

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.startBit |=> !outBitQ);
  // R3
  data_order_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.driveData |=> (outBitQ == $past(holdQ[bitSel])));
  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadByte |=> $stable(holdQ));
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sftx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  localparam int SEL_W = $clog2(DATA_BITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bitTick,
  input  logic [DATA_BITS-1:0] txByte,
  input  logic                 sendReq,
  output logic                 ready,
  output logic                 txLine
);
  sftx_strobe_t     strobes;
  logic [SEL_W-1:0] bitSel;
  logic             lineIdle;

  sftx_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
    .clk(clk), .rst(rst), .bitTick(bitTick), .sendReq(sendReq),
    .strobes(strobes), .bitSel(bitSel), .lineIdle(lineIdle), .ready(ready)
  );

  sftx_datapath #(.DATA_BITS(DATA_BITS)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .bitSel(bitSel),
    .lineIdle(lineIdle), .byteIn(txByte), .lineOut(txLine)
  );

  // R4
  stop_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (bitTick && !ready) |=> (txLine && ready));
  // R5
  ready_single_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready && !bitTick) |=> !ready);
endmodule

// File: tb/sim_serial_frame_tx.sv
module sim_serial_frame_tx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bitTick = 1'b0;
  logic [7:0] txByte = 8'h00;
  logic       sendReq = 1'b0;
  logic       ready;
  logic       txLine;
  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  serial_frame_tx u0 (.clk(clk), .rst(rst), .bitTick(bitTick), .txByte(txByte),
    .sendReq(sendReq), .ready(ready), .txLine(txLine));

  localparam int NVEC = 6;
  localparam logic [7:0] VEC [NVEC] = '{8'hA5, 8'h00, 8'hFF, 8'h01, 8'h80, 8'h3C};

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      total = total + 1; bad = bad + 1;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // one tick cycle, then a gap; sampling happens after the return
  task automatic pulseTick();
    @(negedge clk) bitTick = 1'b1;
    @(negedge clk) bitTick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic strobe(logic [7:0] b, logic withTick);
    @(negedge clk) begin txByte = b; sendReq = 1'b1; bitTick = withTick; end
    @(negedge clk) begin sendReq = 1'b0; bitTick = 1'b0; txByte = ~b; end
  endtask

  // mode 0 plain, 1 strobe with tick, 2 intruding strobe, 3 double strobe
  task automatic sendFrame(logic [7:0] b, int mode);
    strobe(b, mode == 1);
    if (mode == 1) chk("R8 no start on same-cycle tick", txLine, 1'b1);
    if (mode == 3) strobe(~b, 1'b0);
    pulseTick();
    chk("R2 start bit", txLine, 1'b0);
    chk("R5 ready in start", ready, 1'b1);
    for (int i = 0; i < 8; i++) begin
      pulseTick();
      if (mode == 2 && i == 3) strobe(8'h5A ^ b, 1'b0);
      chk("R3 data bit", txLine, b[7-i]);
      chk("R5 ready", ready, (i == 7) ? 1'b0 : 1'b1);
    end
    pulseTick();
    chk("R4 stop high", txLine, 1'b1);
    chk("R5 ready after frame", ready, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 line in reset", txLine, 1'b1);
    chk("R1 ready in reset", ready, 1'b1);
    rst = 1'b0;
    @(negedge clk);
    // R9 idle ticks keep line high
    pulseTick();
    chk("R9 idle tick", txLine, 1'b1);
    pulseTick();
    chk("R9 idle tick", txLine, 1'b1);

    for (int v = 0; v < NVEC; v++) sendFrame(VEC[v], 0);

    // R6 hold between ticks during a frame
    strobe(8'hC3, 1'b0);
    pulseTick();
    pulseTick();
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk("R6 hold without tick", txLine, 1'b1);
    end
    for (int i = 1; i < 8; i++) begin
      pulseTick();
      chk("R6 frame resumes", txLine, 8'hC3 >> (7 - i));
    end
    pulseTick();
    chk("R4 stop", txLine, 1'b1);

    // R4 back-to-back: strobe right after stop begins, line high until next tick
    strobe(8'h00, 1'b0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R4 stop held before start", txLine, 1'b1);
    end
    pulseTick();
    chk("R4 start after full stop", txLine, 1'b0);
    for (int i = 0; i < 9; i++) pulseTick();
    chk("R4 line high after frame", txLine, 1'b1);

    // R8 strobe coinciding with tick
    sendFrame(8'h96, 1);
    // R7 strobe during frame ignored
    sendFrame(8'h4B, 2);
    pulseTick();
    chk("R7 no extra frame", txLine, 1'b1);
    // R10 second strobe while armed ignored
    sendFrame(8'hE1, 3);
    pulseTick();
    chk("R10 no extra frame", txLine, 1'b1);

    // R1 reset mid-frame
    strobe(8'h00, 1'b0);
    pulseTick();
    for (int i = 0; i < 8; i++) pulseTick();
    chk("R5 last bit ready low", ready, 1'b0);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk("R1 line after mid reset", txLine, 1'b1);
    chk("R1 ready after mid reset", ready, 1'b1);
    pulseTick();
    chk("R1 idle after mid reset", txLine, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule